// File: doc/BRIEF.md
# Three-Segment Cassette Bit Encoder

This block turns a stream of bytes into the digital tone line of a cassette recording. Every bit period is cut into three segments of equal length. The first segment always carries tone. The middle segment carries tone for a one and silence for a zero. The last segment is always silent. A one therefore has about two-thirds tone and a zero about one-third. A playback decoder only has to judge that duty cycle, so the format tolerates speed drift and level changes on the tape.

A recording begins when `start_i` is pulsed while the block is idle. The block first plays a continuous tone leader. It then sends the ten ASCII digits from '9' down to '0' as ordinary bytes. User bytes follow through a valid/ready handshake.

Each byte is sent least-significant bit first and is closed by one extra zero bit, so a byte takes nine bit periods. At each byte boundary after the countdown, the block raises `ready_o` for a single clock. If no byte is offered in that clock, the recording ends.

Top module: `tape_bit_encoder`

## Requirements
- R1: After reset, `tone_o`, `busy_o` and `ready_o` are all low.
- R2: A `start_i` pulse while idle begins the leader. From the first clock after the pulse, the leader is LEADER_CYCLES whole tone cycles, starting high. `start_i` during a recording and `valid_i` while idle have no effect.
- R3: The tone is a square wave that is high for HALF_CLKS clocks and then low for HALF_CLKS clocks, where HALF_CLKS = CLK_HZ/(2*TONE_HZ). Silence holds `tone_o` low.
- R4: A bit lasts 3*CYCLES_PER_SEG tone cycles, split into three equal segments. Segment one is tone. Segment two is tone for a 1 and low for a 0. Segment three is low. Every tone segment starts on a fresh high half-cycle.
- R5: The eight data bits of a byte are sent bit 0 first, followed by a ninth bit of value 0.
- R6: Immediately after the leader, the bytes 0x39 down to 0x30 ('9' to '0') are sent back to back with no gap.
- R7: After the countdown and after each user byte, `ready_o` is high for exactly one clock, with `tone_o` low. If `valid_i` is high in that clock, `data_i` is taken and its first bit starts on the next clock.
- R8: If `valid_i` is low while `ready_o` is high, the recording ends and `busy_o` is low on the next clock.
- R9: `busy_o` is high from the first leader clock until the recording ends. `ready_o` stays low while a byte is being sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to begin a recording |
| data_i | input | 8 | User byte to record |
| valid_i | input | 1 | `data_i` holds a byte on offer |
| ready_o | output | 1 | Byte boundary; a byte offered now is taken |
| busy_o | output | 1 | A recording is in progress |
| tone_o | output | 1 | Digital tone line toward the analog driver |

## Verification
The bench sweeps all 256 byte values through a small configuration and compares `tone_o` clock by clock against a waveform built arithmetically from the segment rules. A wrong shift direction, a missing or set ninth bit, or a swapped middle segment would each change the duty cycle of particular bits. The exact leader length and the countdown values are checked, because an off-by-one cycle count would shift every later edge. A segment that did not restart its tone on a high half-cycle would show as a phase error right after the single-clock ready gap. The bench also checks that stray start pulses and idle valid strobes are ignored. It confirms that an unanswered ready ends the recording at once rather than hanging in a busy state.

// File: rtl/tbe_pkg.sv
package tbe_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEADER,
        ST_SHIFT,
        ST_WAIT
    } tbe_state_e;

    localparam logic [7:0] DIGIT_ZERO = 8'h30;
    localparam int unsigned BITS_PER_FRAME = 9;
    localparam int unsigned SEGS_PER_BIT = 3;

endpackage

// File: rtl/tbe_tone_timer.sv
module tbe_tone_timer #(
    parameter int unsigned HALF_CLKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    output logic phase_hi_o,
    output logic cyc_end_o
);
    localparam int unsigned PERIOD = 2 * HALF_CLKS;
    localparam int unsigned PW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

    logic [PW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (restart_i || cnt_q == PW'(PERIOD - 1)) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign phase_hi_o = (cnt_q < PW'(HALF_CLKS));
    assign cyc_end_o  = (cnt_q == PW'(PERIOD - 1));

endmodule

// File: rtl/tbe_sequencer.sv
module tbe_sequencer
    import tbe_pkg::*;
#(
    parameter int unsigned CYCLES_PER_SEG = 5,
    parameter int unsigned LEADER_CYCLES  = 30000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [7:0] data_i,
    input  logic       valid_i,
    input  logic       cyc_end_i,
    output logic       ready_o,
    output logic       busy_o,
    output logic       tone_en_o,
    output logic       timer_restart_o
);
    localparam int unsigned MAXC = (LEADER_CYCLES > CYCLES_PER_SEG) ? LEADER_CYCLES : CYCLES_PER_SEG;
    localparam int unsigned CW   = $clog2(MAXC) + 1;

    typedef struct packed {
        tbe_state_e  st;
        logic [CW-1:0] cyc;
        logic [1:0]  seg;
        logic [3:0]  bit_idx;
        logic [3:0]  digit;
        logic        in_cd;
        logic [8:0]  sh;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    s_d.st  = ST_LEADER;
                    s_d.cyc = '0;
                end
            end
            ST_LEADER: begin
                if (cyc_end_i) begin
                    if (s_q.cyc == CW'(LEADER_CYCLES - 1)) begin
                        s_d.st      = ST_SHIFT;
                        s_d.cyc     = '0;
                        s_d.seg     = '0;
                        s_d.bit_idx = '0;
                        s_d.digit   = 4'd9;
                        s_d.in_cd   = 1'b1;
                        s_d.sh      = {1'b0, DIGIT_ZERO + 8'd9};
                    end else begin
                        s_d.cyc = s_q.cyc + 1'b1;
                    end
                end
            end
            ST_SHIFT: begin
                if (cyc_end_i) begin
                    if (s_q.cyc == CW'(CYCLES_PER_SEG - 1)) begin
                        s_d.cyc = '0;
                        if (s_q.seg == 2'(SEGS_PER_BIT - 1)) begin
                            s_d.seg = '0;
                            if (s_q.bit_idx == 4'(BITS_PER_FRAME - 1)) begin
                                s_d.bit_idx = '0;
                                if (s_q.in_cd && s_q.digit != 4'd0) begin
                                    s_d.digit = s_q.digit - 1'b1;
                                    s_d.sh    = {1'b0, DIGIT_ZERO + {4'd0, s_q.digit - 4'd1}};
                                end else begin
                                    s_d.in_cd = 1'b0;
                                    s_d.st    = ST_WAIT;
                                end
                            end else begin
                                s_d.bit_idx = s_q.bit_idx + 1'b1;
                                s_d.sh      = {1'b0, s_q.sh[8:1]};
                            end
                        end else begin
                            s_d.seg = s_q.seg + 1'b1;
                        end
                    end else begin
                        s_d.cyc = s_q.cyc + 1'b1;
                    end
                end
            end
            ST_WAIT: begin
                if (valid_i) begin
                    s_d.st      = ST_SHIFT;
                    s_d.cyc     = '0;
                    s_d.seg     = '0;
                    s_d.bit_idx = '0;
                    s_d.sh      = {1'b0, data_i};
                end else begin
                    s_d.st = ST_IDLE;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, cyc: '0, seg: '0, bit_idx: '0,
                     digit: '0, in_cd: 1'b0, sh: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign ready_o         = (s_q.st == ST_WAIT);
    assign busy_o          = (s_q.st != ST_IDLE);
    assign timer_restart_o = (s_q.st == ST_IDLE) || (s_q.st == ST_WAIT);
    assign tone_en_o       = (s_q.st == ST_LEADER) ||
                             ((s_q.st == ST_SHIFT) &&
                              ((s_q.seg == 2'd0) || (s_q.seg == 2'd1 && s_q.sh[0])));

endmodule

// File: rtl/tape_bit_encoder.sv
module tape_bit_encoder #(
    parameter int unsigned CLK_HZ         = 50_000_000,
    parameter int unsigned TONE_HZ        = 2000,
    parameter int unsigned CYCLES_PER_SEG = 5,
    parameter int unsigned LEADER_CYCLES  = 30000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [7:0] data_i,
    input  logic       valid_i,
    output logic       ready_o,
    output logic       busy_o,
    output logic       tone_o
);
    localparam int unsigned HALF_CLKS = CLK_HZ / (2 * TONE_HZ);

    logic phase_hi, cyc_end, tone_en, restart;

    tbe_tone_timer #(.HALF_CLKS(HALF_CLKS)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart_i  (restart),
        .phase_hi_o (phase_hi),
        .cyc_end_o  (cyc_end)
    );

    tbe_sequencer #(
        .CYCLES_PER_SEG(CYCLES_PER_SEG),
        .LEADER_CYCLES (LEADER_CYCLES)
    ) u_seq (
        .clk             (clk),
        .rst_n           (rst_n),
        .start_i         (start_i),
        .data_i          (data_i),
        .valid_i         (valid_i),
        .cyc_end_i       (cyc_end),
        .ready_o         (ready_o),
        .busy_o          (busy_o),
        .tone_en_o       (tone_en),
        .timer_restart_o (restart)
    );

    assign tone_o = tone_en & phase_hi;

endmodule

// File: rtl/tbe_checker.sv
module tbe_checker #(
    parameter int unsigned HALF_CLKS = 4
) (
    input logic clk,
    input logic rst_n,
    input logic valid_i,
    input logic ready_o,
    input logic busy_o,
    input logic tone_o
);
    localparam int unsigned RW = $clog2(HALF_CLKS + 2) + 1;

    logic [RW-1:0] hi_run;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_run <= '0;
        end else if (tone_o) begin
            if (hi_run <= RW'(HALF_CLKS)) hi_run <= hi_run + 1'b1;
        end else begin
            hi_run <= '0;
        end
    end

    p_high_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hi_run <= RW'(HALF_CLKS));

    p_first_leader_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> tone_o);

    p_tone_only_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tone_o |-> busy_o);

    p_ready_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> (busy_o && !tone_o));

    p_ready_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |=> !ready_o);

    p_take_starts_tone_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && valid_i) |=> (tone_o && busy_o));

    p_end_on_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && !valid_i) |=> !busy_o);

endmodule

bind tape_bit_encoder tbe_checker #(.HALF_CLKS(HALF_CLKS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid_i (valid_i),
    .ready_o (ready_o),
    .busy_o  (busy_o),
    .tone_o  (tone_o)
);

// File: tb/tape_bit_encoder_tb.sv
`timescale 1ns/1ps
module tape_bit_encoder_tb;
    localparam int unsigned CLK_HZ = 16;
    localparam int unsigned TONE_HZ = 2;
    localparam int unsigned H = CLK_HZ / (2 * TONE_HZ);
    localparam int unsigned CPS = 2;
    localparam int unsigned LEAD = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [7:0] data_i = '0;
    logic valid_i = 1'b0;
    logic ready_o, busy_o, tone_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tape_bit_encoder #(
        .CLK_HZ(CLK_HZ), .TONE_HZ(TONE_HZ),
        .CYCLES_PER_SEG(CPS), .LEADER_CYCLES(LEAD)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .data_i(data_i),
        .valid_i(valid_i), .ready_o(ready_o), .busy_o(busy_o), .tone_o(tone_o)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Starts at the negedge inside the first clock of the span.
    task automatic expect_span(input string req, input int cycles, input bit on);
        int mism = 0;
        int a_first = 0, e_first = 0;
        for (int c = 0; c < cycles; c++) begin
            for (int k = 0; k < 2 * int'(H); k++) begin
                int e;
                e = (on && k < int'(H)) ? 1 : 0;
                if (int'(tone_o) != e || busy_o != 1'b1 || ready_o != 1'b0) begin
                    if (mism == 0) begin
                        a_first = {ready_o, busy_o, tone_o};
                        e_first = {1'b0, 1'b1, e[0]};
                    end
                    mism++;
                end
                if (req == "R2" && c == 1 && k == 0) start_i = 1'b1;
                else start_i = 1'b0;
                @(negedge clk);
            end
        end
        check(req, a_first, e_first);
    endtask

    task automatic expect_byte(input string req, input logic [7:0] v);
        logic [8:0] fr;
        fr = {1'b0, v};
        for (int b = 0; b < 9; b++) begin
            expect_span(req, CPS, 1'b1);
            expect_span(req, CPS, fr[b]);
            expect_span(req, CPS, 1'b0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 tone", tone_o, 0);
        check("R1 busy", busy_o, 0);
        check("R1 ready", ready_o, 0);
        rst_n = 1'b1;
        valid_i = 1'b1;
        data_i = 8'h55;
        repeat (5) @(negedge clk);
        check("R2 idle valid ignored ready", ready_o, 0);
        check("R2 idle valid ignored busy", busy_o, 0);
        check("R2 idle tone", tone_o, 0);
        valid_i = 1'b0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check("R9 busy at leader", busy_o, 1);
        expect_span("R2", LEAD, 1'b1);
        for (int d = 9; d >= 0; d--) expect_byte("R6", 8'h30 + 8'(d));
        for (int v = 0; v < 256; v++) begin
            check("R7 ready", ready_o, 1);
            check("R7 tone quiet", tone_o, 0);
            valid_i = 1'b1;
            data_i = 8'(v);
            @(negedge clk);
            valid_i = 1'b0;
            data_i = 8'hFF;
            expect_byte((v % 2 == 0) ? "R5" : "R4", 8'(v));
        end
        check("R8 ready at end", ready_o, 1);
        @(negedge clk);
        check("R8 busy", busy_o, 0);
        check("R8 tone", tone_o, 0);
        repeat (4 * H) @(negedge clk);
        check("R3 idle silent", tone_o, 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule